// File: doc/BRIEF.md
# Instruction Fetch Miss Detector with Line-Fill Buffer

This block sits between the instruction fetch pipe and the external memory port of an instruction cache. For each fetch it accepts, it decides whether the fetch can be served locally or needs an external memory access. Two local sources count. The first is a small line-fill buffer that keeps the most recently fetched 16-byte line, with a valid bit for each 32-bit word. The second is the tag-hit signal from the cache arrays, which sit outside this block. A fetch goes to external memory only when it misses both.

The size of an external access comes from a 2-bit fill-mode setting and the position of the missed word within its line. A full-line access returns four beats in ascending order from the line base. Each beat is written into the buffer. The addressed word is returned to the fetch pipe once the access completes.

When the cache is disabled, or the fetch is marked noncacheable, the block makes a single-word access and leaves the buffer untouched. The fetch, external request, external data and response channels all use valid/ready handshakes. The block handles one fetch at a time. `fq_ready` is high only while the block is idle. Once raised, a response or external request holds its contents until it is taken. External data beats are taken whenever `xr_ready` is high.

Top module: `ifu_fill_unit`

## Requirements
- R1: After reset, no response or external request is pending, `fq_ready` is 1, and every buffer word is invalid. The first cacheable fetch with a tag miss therefore goes external.
- R2: With the cache enabled, a cacheable fetch whose line address (bits [31:4]) equals the buffer line and whose word (bits [3:2]) is valid gets a response with `fr_src`=01 and that word's data, and no external request is made. The buffer is checked ahead of the tag-hit input.
- R3: With the cache enabled, a cacheable fetch that misses the buffer while `tag_hit`=1 gets a response with `fr_src`=00 and data 0, and no external request is made.
- R4: An external request is made only when a cacheable, enabled fetch misses both the buffer and the tag. The response then carries `fr_src`=10 and the word read from memory.
- R5: A fetch with `cfg_enable`=0, or with `fq_cacheable`=0, ignores the buffer and `tag_hit`. It always makes a single-word request (`xq_line`=0, address bits [1:0]=0), and the buffer contents stay unchanged.
- R6: With fill mode 00 or 01, a cached miss requests a full line (`xq_line`=1).
- R7: With fill mode 10, a cached miss requests a full line when word index bits [3:2] are 0 or 1, and a single word when they are 2 or 3.
- R8: With fill mode 11, a cached miss requests a single word. The buffer is re-tagged to that line, and only that word is marked valid.
- R9: A full-line request carries the line base address (bits [3:0]=0). Its four beats fill words 0 to 3 in order. The response returns the addressed word.
- R10: `fq_ready` is 0 from the cycle after a fetch is accepted until that fetch's response is taken. While `fr_ready` is 0, `fr_valid`, `fr_data` and `fr_src` hold steady.
- R11: While `xq_ready` is 0, `xq_valid`, `xq_addr` and `xq_line` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Cache enable |
| cfg_mode | input | 2 | Fill-size mode |
| fq_valid | input | 1 | Fetch request valid |
| fq_ready | output | 1 | Fetch request accepted when high |
| fq_addr | input | 32 | Fetch byte address |
| fq_cacheable | input | 1 | Fetch is cacheable |
| tag_hit | input | 1 | Tag array hit for the offered fetch |
| fr_valid | output | 1 | Response valid |
| fr_ready | input | 1 | Response taken when high |
| fr_data | output | 32 | Instruction word (0 for a tag hit) |
| fr_src | output | 2 | Source of the response: 00 tag, 01 buffer, 10 external |
| xq_valid | output | 1 | External request valid |
| xq_ready | input | 1 | External request accepted |
| xq_addr | output | 32 | External request address |
| xq_line | output | 1 | 1 for a four-beat line, 0 for one word |
| xr_valid | input | 1 | External data beat valid |
| xr_ready | output | 1 | External data beat accepted |
| xr_data | input | 32 | External data beat |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and words, and four words per line. With these, every fill-mode value and both halves of the line are reachable with a handful of addresses. A reference model in the bench tracks the buffer line and its word-valid bits, and predicts the source and data of each response and the address and size of each external request. The bench adds back-pressure on both the response and the external request. It also switches enable and cacheability between fetches, to show that uncached traffic leaves the buffered words reachable.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [1:0] {
    SRC_TAG = 2'b00,
    SRC_BUF = 2'b01,
    SRC_EXT = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_BEAT,
    ST_RESP
  } state_e;

  // Fill-size choice: 0x full line, 10 full line only in the lower half,
  // 11 always a single word.
  function automatic logic line_wanted(input logic [1:0] mode, input logic upper_half);
    case (mode)
      2'b00, 2'b01: line_wanted = 1'b1;
      2'b10:        line_wanted = !upper_half;
      default:      line_wanted = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ifu_fill_buffer.sv
module ifu_fill_buffer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             lk_addr,
  output logic                          lk_hit,
  output logic [DATA_W-1:0]             lk_data,
  input  logic                          open_en,
  input  logic [ADDR_W-1:0]             open_addr,
  input  logic                          wr_en,
  input  logic [$clog2(WORDS)-1:0]      wr_idx,
  input  logic [DATA_W-1:0]             wr_data
);
  localparam int WB_W  = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFF_W = WB_W + IDX_W;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]  tag_q;
  logic [WORDS-1:0]  vld;
  logic [DATA_W-1:0] words [WORDS];
  logic [IDX_W-1:0]  lk_idx;

  assign lk_idx = lk_addr[OFF_W-1:WB_W];

  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else if (open_en) tag_q <= open_addr[ADDR_W-1:OFF_W];
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (open_en) begin
        v_q <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
        d_q <= wr_data;
      end
    end
    assign vld[g]   = v_q;
    assign words[g] = d_q;
  end

  assign lk_hit  = (lk_addr[ADDR_W-1:OFF_W] == tag_q) && vld[lk_idx];
  assign lk_data = words[lk_idx];

endmodule

// File: rtl/ifu_miss_detect.sv
module ifu_miss_detect #(
  parameter int WORDS = 4
) (
  input  logic                     cfg_enable,
  input  logic [1:0]               cfg_mode,
  input  logic                     cacheable,
  input  logic                     tag_hit,
  input  logic                     buf_hit,
  input  logic [$clog2(WORDS)-1:0] word_idx,
  output logic                     take_buf,
  output logic                     take_tag,
  output logic                     ext_line,
  output logic                     fill_buf
);
  import ifu_pkg::*;
  localparam int IDX_W = $clog2(WORDS);

  logic cached;
  logic upper;

  assign cached   = cfg_enable && cacheable;
  assign upper    = word_idx[IDX_W-1];
  assign take_buf = cached && buf_hit;
  assign take_tag = cached && !buf_hit && tag_hit;
  assign ext_line = cached && line_wanted(cfg_mode, upper);
  assign fill_buf = cached;

endmodule

// File: rtl/ifu_fetch_ctrl.sv
module ifu_fetch_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fq_valid,
  output logic                     fq_ready,
  input  logic [ADDR_W-1:0]        fq_addr,
  input  logic                     take_buf,
  input  logic                     take_tag,
  input  logic                     ext_line,
  input  logic                     fill_buf,
  input  logic [DATA_W-1:0]        buf_data,
  output logic                     open_en,
  output logic                     wr_en,
  output logic [$clog2(WORDS)-1:0] wr_idx,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     fr_valid,
  input  logic                     fr_ready,
  output logic [DATA_W-1:0]        fr_data,
  output logic [1:0]               fr_src,
  output logic                     xq_valid,
  input  logic                     xq_ready,
  output logic [ADDR_W-1:0]        xq_addr,
  output logic                     xq_line,
  input  logic                     xr_valid,
  output logic                     xr_ready,
  input  logic [DATA_W-1:0]        xr_data
);
  import ifu_pkg::*;
  localparam int WB_W  = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFF_W = WB_W + IDX_W;

  state_e             st_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               line_q;
  logic               fill_q;
  logic [IDX_W-1:0]   beat_q;
  logic [DATA_W-1:0]  data_q;
  src_e               src_q;
  logic [IDX_W-1:0]   widx_q;
  logic               accept;
  logic               beat_take;
  logic               beat_last;
  logic               beat_mine;

  assign widx_q    = addr_q[OFF_W-1:WB_W];
  assign fq_ready  = (st_q == ST_IDLE);
  assign accept    = fq_valid && fq_ready;
  assign xr_ready  = (st_q == ST_BEAT);
  assign beat_take = xr_valid && xr_ready;
  assign beat_last = line_q ? (beat_q == IDX_W'(WORDS - 1)) : 1'b1;
  assign beat_mine = line_q ? (beat_q == widx_q) : 1'b1;

  assign open_en = accept && !take_buf && !take_tag && fill_buf;
  assign wr_en   = beat_take && fill_q;
  assign wr_idx  = line_q ? beat_q : widx_q;
  assign wr_data = xr_data;

  assign xq_valid = (st_q == ST_REQ);
  assign xq_line  = line_q;
  assign xq_addr  = line_q ? {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                           : {addr_q[ADDR_W-1:WB_W], {WB_W{1'b0}}};

  assign fr_valid = (st_q == ST_RESP);
  assign fr_data  = data_q;
  assign fr_src   = src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      line_q <= 1'b0;
      fill_q <= 1'b0;
      beat_q <= '0;
      data_q <= '0;
      src_q  <= SRC_TAG;
    end else begin
      case (st_q)
        ST_IDLE: if (fq_valid) begin
          addr_q <= fq_addr;
          if (take_buf) begin
            data_q <= buf_data;
            src_q  <= SRC_BUF;
            st_q   <= ST_RESP;
          end else if (take_tag) begin
            data_q <= '0;
            src_q  <= SRC_TAG;
            st_q   <= ST_RESP;
          end else begin
            line_q <= ext_line;
            fill_q <= fill_buf;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ: if (xq_ready) begin
          beat_q <= '0;
          st_q   <= ST_BEAT;
        end
        ST_BEAT: if (beat_take) begin
          if (beat_mine) data_q <= xr_data;
          beat_q <= beat_q + 1'b1;
          if (beat_last) begin
            src_q <= SRC_EXT;
            st_q  <= ST_RESP;
          end
        end
        ST_RESP: if (fr_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ifu_fill_unit.sv
module ifu_fill_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic              fq_valid,
  output logic              fq_ready,
  input  logic [ADDR_W-1:0] fq_addr,
  input  logic              fq_cacheable,
  input  logic              tag_hit,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [DATA_W-1:0] fr_data,
  output logic [1:0]        fr_src,
  output logic              xq_valid,
  input  logic              xq_ready,
  output logic [ADDR_W-1:0] xq_addr,
  output logic              xq_line,
  input  logic              xr_valid,
  output logic              xr_ready,
  input  logic [DATA_W-1:0] xr_data
);
  localparam int WB_W  = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFF_W = WB_W + IDX_W;

  logic              buf_hit;
  logic [DATA_W-1:0] buf_data;
  logic              take_buf, take_tag, ext_line, fill_buf;
  logic              open_en, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  ifu_fill_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
    .clk(clk), .rst(rst),
    .lk_addr(fq_addr), .lk_hit(buf_hit), .lk_data(buf_data),
    .open_en(open_en), .open_addr(fq_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  ifu_miss_detect #(.WORDS(WORDS)) u_detect (
    .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cacheable(fq_cacheable), .tag_hit(tag_hit), .buf_hit(buf_hit),
    .word_idx(fq_addr[OFF_W-1:WB_W]),
    .take_buf(take_buf), .take_tag(take_tag),
    .ext_line(ext_line), .fill_buf(fill_buf)
  );

  ifu_fetch_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst(rst),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_addr(fq_addr),
    .take_buf(take_buf), .take_tag(take_tag),
    .ext_line(ext_line), .fill_buf(fill_buf), .buf_data(buf_data),
    .open_en(open_en), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data), .fr_src(fr_src),
    .xq_valid(xq_valid), .xq_ready(xq_ready), .xq_addr(xq_addr), .xq_line(xq_line),
    .xr_valid(xr_valid), .xr_ready(xr_ready), .xr_data(xr_data)
  );

endmodule

// File: rtl/ifu_fill_unit_chk.sv
module ifu_fill_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic [1:0]        cfg_mode,
  input logic              fq_valid,
  input logic              fq_ready,
  input logic [ADDR_W-1:0] fq_addr,
  input logic              fq_cacheable,
  input logic              tag_hit,
  input logic              fr_valid,
  input logic              fr_ready,
  input logic [DATA_W-1:0] fr_data,
  input logic [1:0]        fr_src,
  input logic              xq_valid,
  input logic              xq_ready,
  input logic [ADDR_W-1:0] xq_addr,
  input logic              xq_line
);
  localparam int OFF_W = $clog2(DATA_W / 8) + $clog2(WORDS);

  logic       acc_cached;
  logic [1:0] acc_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cached <= 1'b0;
      acc_mode   <= 2'b00;
    end else if (fq_valid && fq_ready) begin
      acc_cached <= cfg_enable && fq_cacheable;
      acc_mode   <= cfg_mode;
    end
  end

  assert_tag_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    fq_valid && fq_ready && cfg_enable && fq_cacheable && tag_hit |=> !xq_valid);

  assert_uncached_word_R5: assert property (@(posedge clk) disable iff (rst)
    xq_valid && !acc_cached |-> !xq_line);

  assert_mode_word_R8: assert property (@(posedge clk) disable iff (rst)
    xq_valid && acc_cached && acc_mode == 2'b11 |-> !xq_line);

  assert_line_base_R9: assert property (@(posedge clk) disable iff (rst)
    xq_valid && xq_line |-> xq_addr[OFF_W-1:0] == '0);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    fq_valid && fq_ready |=> !fq_ready);

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    fr_valid && !fr_ready |=> fr_valid && $stable(fr_data) && $stable(fr_src));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    xq_valid && !xq_ready |=> xq_valid && $stable(xq_addr) && $stable(xq_line));

endmodule

bind ifu_fill_unit ifu_fill_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
  .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_addr(fq_addr),
  .fq_cacheable(fq_cacheable), .tag_hit(tag_hit),
  .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data), .fr_src(fr_src),
  .xq_valid(xq_valid), .xq_ready(xq_ready), .xq_addr(xq_addr), .xq_line(xq_line)
);

// File: tb/ifu_fill_unit_bench.sv
module ifu_fill_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        fq_valid = 1'b0;
  logic        fq_ready;
  logic [31:0] fq_addr = '0;
  logic        fq_cacheable = 1'b0;
  logic        tag_hit = 1'b0;
  logic        fr_valid;
  logic        fr_ready = 1'b0;
  logic [31:0] fr_data;
  logic [1:0]  fr_src;
  logic        xq_valid;
  logic        xq_ready = 1'b0;
  logic [31:0] xq_addr;
  logic        xq_line;
  logic        xr_valid = 1'b0;
  logic        xr_ready;
  logic [31:0] xr_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ifu_fill_unit u_ifu_fill_unit (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_addr(fq_addr),
    .fq_cacheable(fq_cacheable), .tag_hit(tag_hit),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data), .fr_src(fr_src),
    .xq_valid(xq_valid), .xq_ready(xq_ready), .xq_addr(xq_addr), .xq_line(xq_line),
    .xr_valid(xr_valid), .xr_ready(xr_ready), .xr_data(xr_data)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  // reference model state
  logic [27:0] mb_tag = '0;
  logic [3:0]  mb_v = '0;
  logic [31:0] q_xaddr[$];
  bit          q_xline[$];
  string       q_xtag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // external memory responder
  initial begin : responder
    int dly = 0;
    forever begin
      @(negedge clk);
      if (xq_valid) begin
        logic [31:0] a;
        bit          ln;
        a  = xq_addr;
        ln = xq_line;
        dly = (dly + 1) % 3;
        for (int i = 0; i < dly; i++) begin
          @(negedge clk);
          check(xq_valid && xq_addr == a && xq_line == ln, "R11",
                "request held", xq_addr, a);
        end
        xq_ready = 1'b1;
        @(negedge clk);
        xq_ready = 1'b0;
        if (q_xaddr.size() == 0) begin
          check(1'b0, "R4", "unexpected external request", a, 32'h0);
        end else begin
          logic [31:0] ea;
          bit          el;
          string       et;
          ea = q_xaddr.pop_front();
          el = q_xline.pop_front();
          et = q_xtag.pop_front();
          check(a == ea, et, "request address", a, ea);
          check(ln == el, et, "request size", {31'b0, ln}, {31'b0, el});
        end
        for (int b = 0; b < (ln ? 4 : 1); b++) begin
          xr_valid = 1'b1;
          xr_data  = memf(a + 32'(4 * b));
          @(negedge clk);
          xr_valid = 1'b0;
          if (b == 1) @(negedge clk);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mb_v = '0;
    @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] a, input bit c, input bit th,
                       input int bp, input string tag);
    logic [1:0]  es;
    logic [31:0] ed;
    logic [31:0] wa;
    bit          cached;
    bit          lf;
    int          w;
    wa = {a[31:2], 2'b00};
    w  = int'(a[3:2]);
    cached = cfg_enable && c;
    if (cached && mb_tag == a[31:4] && mb_v[w]) begin
      es = 2'b01; ed = memf(wa);
    end else if (cached && th) begin
      es = 2'b00; ed = '0;
    end else begin
      lf = cached && (cfg_mode[1] == 1'b0 || (cfg_mode == 2'b10 && w < 2));
      q_xaddr.push_back(lf ? {a[31:4], 4'b0000} : wa);
      q_xline.push_back(lf);
      q_xtag.push_back(tag);
      es = 2'b10; ed = memf(wa);
      if (cached) begin
        mb_tag = a[31:4];
        mb_v   = lf ? 4'hF : (4'b0001 << w);
      end
    end
    @(negedge clk);
    fq_valid = 1'b1; fq_addr = a; fq_cacheable = c; tag_hit = th;
    while (!fq_ready) @(negedge clk);
    @(negedge clk);
    fq_valid = 1'b0;
    check(!fq_ready, "R10", "fq_ready low while busy", {31'b0, fq_ready}, 32'h0);
    while (!fr_valid) @(negedge clk);
    for (int i = 0; i < bp; i++) begin
      logic [31:0] d0;
      d0 = fr_data;
      @(negedge clk);
      check(fr_valid && fr_data == d0, "R10", "response held", fr_data, d0);
    end
    fr_ready = 1'b1;
    check(fr_src == es, tag, "response source", {30'b0, fr_src}, {30'b0, es});
    check(fr_data == ed, tag, "response data", fr_data, ed);
    @(negedge clk);
    fr_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R1: idle outputs after reset
    check(fq_ready && !fr_valid && !xq_valid, "R1", "reset state",
          {29'b0, fq_ready, fr_valid, xq_valid}, 32'h4);
    cfg_enable = 1'b1;
    cfg_mode   = 2'b00;
    fetch(32'h0000_0100, 1, 0, 0, "R4");   // double miss -> line, R6 R9
    fetch(32'h0000_010C, 1, 1, 0, "R2");   // buffer before tag
    fetch(32'h0000_0200, 1, 1, 0, "R3");   // tag hit
    cfg_mode = 2'b01;
    fetch(32'h0000_0208, 1, 0, 2, "R6");   // line, critical word 2, R9
    cfg_mode = 2'b10;
    fetch(32'h0000_0314, 1, 0, 0, "R7");   // lower half -> line
    fetch(32'h0000_031C, 1, 0, 0, "R2");
    fetch(32'h0000_0428, 1, 0, 1, "R7");   // upper half -> word
    fetch(32'h0000_042C, 1, 0, 0, "R7");
    cfg_mode = 2'b11;
    fetch(32'h0000_0504, 1, 0, 0, "R8");
    fetch(32'h0000_0504, 1, 0, 0, "R8");   // buffer hit on that word
    fetch(32'h0000_0500, 1, 0, 0, "R8");   // other word misses
    cfg_mode = 2'b00;
    fetch(32'h0000_0600, 0, 1, 0, "R5");   // noncacheable word
    fetch(32'h0000_0500, 1, 0, 0, "R5");   // buffer untouched
    fetch(32'h0000_0604, 1, 0, 0, "R9");   // line fill
    cfg_enable = 1'b0;
    fetch(32'h0000_0700, 1, 1, 0, "R5");   // disabled ignores tag
    fetch(32'h0000_0608, 1, 0, 0, "R5");   // disabled ignores buffer
    cfg_enable = 1'b1;
    fetch(32'h0000_060C, 1, 0, 0, "R2");   // buffer still holds line
    do_reset();
    fetch(32'h0000_0604, 1, 0, 0, "R1");   // buffer emptied by reset
    repeat (4) @(negedge clk);
    check(q_xaddr.size() == 0, "R4", "all expected requests seen",
          32'(q_xaddr.size()), 32'h0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule